// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the interrupt entry and reset vector fetch of a small 8-bit processor. It owns the program counter, stack pointer and status register. The surrounding core executes instructions, updates the PC and status through plain write strobes, and marks each instruction boundary with `insn_start`. At each boundary the sequencer looks at the pending non-maskable request and at the maskable sources, and picks one of them or neither. If it picks one, it raises `busy`, pushes the return state onto the stack in page one, and loads a new PC from a fixed vector.

Maskable requests come from a bitmask of requesters with separate assert and release strobes, plus a one-shot request bit. A core that has locked up signals this on `jammed`, and no entry starts while that input is high. All memory traffic uses one byte-wide request channel with valid/ready handshake. A request is held stable while `mem_ready` is low and completes on the cycle both are high. Read data must be valid in that same cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_n` is low the status register is 0x04 (I only), SP is 0x00 and `busy` is high. After release the block reads 0xFFFC and then 0xFFFD. It loads PC = {byte@0xFFFD, byte@0xFFFC} and then drops `busy`.
- R2: A boundary is a cycle with `insn_start` high and `busy` low. If the NMI is pending at a boundary, the NMI is taken even when an IRQ is also pending, and its pending flag is cleared. A pending IRQ stays pending and is taken at a later boundary.
- R3: An IRQ is taken only if status bit 2 (I) was 0 when the previous boundary occurred. A clear I written after that boundary does not unmask the IRQ at the current boundary.
- R4: No entry starts at a boundary while `jammed` is high. A pending NMI stays pending and is taken at the first boundary after `jammed` falls.
- R5: An entry writes PC[15:8], then PC[7:0], then status. Each write goes to address {0x01, SP}, and SP then decrements modulo 256, so SP 0x00 wraps to 0xFF.
- R6: The pushed status byte is the current status with bit 4 forced to 0 and bit 5 forced to 1.
- R7: After the pushes the block reads the vector low byte and then the high byte: 0xFFFA/0xFFFB for NMI, 0xFFFE/0xFFFF for IRQ. It loads PC from those two bytes and sets status bit 2. All other status bits keep their values.
- R8: With `mem_ready` held high, `busy` stays high for exactly 7 cycles per entry.
- R9: `irq_set`/`irq_clr` set and release individual source bits, and release wins when both name the same bit in one cycle. The IRQ is pending while any source bit is set.
- R10: `irq_temp` sets a one-shot request that is cleared at the next boundary, whether or not it was serviced.
- R11: While `mem_valid` is high and `mem_ready` is low, address, direction and write data hold and the sequence does not advance.
- R12: The first boundary after an entry completes starts no entry, even when a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| insn_start | input | 1 | Instruction boundary strobe from the core |
| jammed | input | 1 | Core is locked up; blocks entry |
| nmi_req | input | 1 | One-cycle non-maskable request |
| irq_set | input | NUM_SRC | Assert maskable source bits |
| irq_clr | input | NUM_SRC | Release maskable source bits |
| irq_temp | input | 1 | One-shot maskable request |
| pc_we | input | 1 | Core write strobe for PC (ignored while busy) |
| pc_wdata | input | 16 | Core PC value |
| st_we | input | 1 | Core write strobe for status (ignored while busy) |
| st_wdata | input | 8 | Core status value |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with the accepted request |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Status register |
| busy | output | 1 | Reset fetch or interrupt entry in progress |

## Verification
An NMI pulse and a maskable source assert can land in the same cycle, and so both are pending at one boundary. The bench drives them together and then judges the result. It expects the NMI vector reads, and it expects the IRQ to be taken on its own at a later boundary. A one-shot request can also coincide with a boundary at which it is masked. The bench checks that such a request is gone at a later unmasked boundary, and that a stalled push holds its address across the gap.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
  typedef enum logic [3:0] {
    SQ_IDLE, SQ_RST_LO, SQ_RST_HI, SQ_OP1, SQ_OP2,
    SQ_PUSH_HI, SQ_PUSH_LO, SQ_PUSH_ST, SQ_VEC_LO, SQ_VEC_HI
  } seq_state_e;

  localparam int FLAG_I = 2;
  localparam int FLAG_B = 4;
  localparam int FLAG_U = 5;
  localparam logic [7:0] RESET_STATUS = 8'h04;
endpackage

// File: rtl/irqseq_pending.sv
module irqseq_pending #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_set,
  input  logic [NUM_SRC-1:0] irq_clr,
  input  logic               irq_temp,
  input  logic               nmi_req,
  input  logic               nmi_ack,
  input  logic               boundary,
  output logic               nmi_pend,
  output logic               irq_pend
);
  logic [NUM_SRC-1:0] src_q;
  logic               temp_q;
  logic               nmi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      temp_q <= 1'b0;
      nmi_q  <= 1'b0;
    end else begin
      src_q <= (src_q | irq_set) & ~irq_clr;
      if (irq_temp)      temp_q <= 1'b1;
      else if (boundary) temp_q <= 1'b0;
      if (nmi_req)       nmi_q <= 1'b1;
      else if (nmi_ack)  nmi_q <= 1'b0;
    end
  end

  assign nmi_pend = nmi_q;
  assign irq_pend = (|src_q) | temp_q;
endmodule

// File: rtl/irqseq_ctrl.sv
module irqseq_ctrl
  import irqseq_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_RST    = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ    = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_start,
  input  logic        jammed,
  input  logic        nmi_pend,
  input  logic        irq_pend,
  input  logic        pc_we,
  input  logic [15:0] pc_wdata,
  input  logic        st_we,
  input  logic [7:0]  st_wdata,
  input  logic        mem_ready,
  input  logic [7:0]  mem_rdata,
  output logic        nmi_ack,
  output logic        boundary,
  output logic        mem_valid,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic [15:0] pc,
  output logic [7:0]  sp,
  output logic [7:0]  status,
  output logic        busy
);
  seq_state_e state_q, state_d;
  logic [15:0] pc_q;
  logic [7:0]  sp_q, st_q, vec_lo_q;
  logic        i_prev_q, skip_q, is_nmi_q;
  logic        take_nmi, take_irq, accept;
  logic [15:0] vec_base;

  assign boundary = insn_start && (state_q == SQ_IDLE);
  assign take_nmi = boundary && !skip_q && !jammed && nmi_pend;
  assign take_irq = boundary && !skip_q && !jammed && !nmi_pend && irq_pend && !i_prev_q;
  assign nmi_ack  = take_nmi;
  assign vec_base = is_nmi_q ? VEC_NMI : VEC_IRQ;

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      SQ_RST_LO:  begin mem_valid = 1'b1; mem_addr = VEC_RST; end
      SQ_RST_HI:  begin mem_valid = 1'b1; mem_addr = 16'(VEC_RST + 16'd1); end
      SQ_PUSH_HI: begin mem_valid = 1'b1; mem_we = 1'b1; mem_addr = {STACK_PAGE, sp_q}; mem_wdata = pc_q[15:8]; end
      SQ_PUSH_LO: begin mem_valid = 1'b1; mem_we = 1'b1; mem_addr = {STACK_PAGE, sp_q}; mem_wdata = pc_q[7:0]; end
      SQ_PUSH_ST: begin
        mem_valid = 1'b1; mem_we = 1'b1; mem_addr = {STACK_PAGE, sp_q};
        mem_wdata = st_q;
        mem_wdata[FLAG_B] = 1'b0;
        mem_wdata[FLAG_U] = 1'b1;
      end
      SQ_VEC_LO:  begin mem_valid = 1'b1; mem_addr = vec_base; end
      SQ_VEC_HI:  begin mem_valid = 1'b1; mem_addr = 16'(vec_base + 16'd1); end
      default: ;
    endcase
  end

  assign accept = mem_valid && mem_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:    if (take_nmi || take_irq) state_d = SQ_OP1;
      SQ_OP1:     state_d = SQ_OP2;
      SQ_OP2:     state_d = SQ_PUSH_HI;
      SQ_RST_LO:  if (accept) state_d = SQ_RST_HI;
      SQ_RST_HI:  if (accept) state_d = SQ_IDLE;
      SQ_PUSH_HI: if (accept) state_d = SQ_PUSH_LO;
      SQ_PUSH_LO: if (accept) state_d = SQ_PUSH_ST;
      SQ_PUSH_ST: if (accept) state_d = SQ_VEC_LO;
      SQ_VEC_LO:  if (accept) state_d = SQ_VEC_HI;
      SQ_VEC_HI:  if (accept) state_d = SQ_IDLE;
      default:    state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SQ_RST_LO;
      pc_q     <= '0;
      sp_q     <= '0;
      st_q     <= RESET_STATUS;
      vec_lo_q <= '0;
      i_prev_q <= 1'b1;
      skip_q   <= 1'b0;
      is_nmi_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == SQ_IDLE) begin
        if (pc_we) pc_q <= pc_wdata;
        if (st_we) st_q <= st_wdata;
      end
      if (boundary) begin
        i_prev_q <= st_q[FLAG_I];
        skip_q   <= 1'b0;
      end
      if (take_nmi || take_irq) is_nmi_q <= take_nmi;
      if (accept && mem_we) sp_q <= sp_q - 8'd1;
      if (accept && state_q == SQ_PUSH_ST) st_q[FLAG_I] <= 1'b1;
      if (accept && (state_q == SQ_RST_LO || state_q == SQ_VEC_LO)) vec_lo_q <= mem_rdata;
      if (accept && (state_q == SQ_RST_HI || state_q == SQ_VEC_HI)) pc_q <= {mem_rdata, vec_lo_q};
      if (accept && state_q == SQ_VEC_HI) skip_q <= 1'b1;
    end
  end

  assign pc     = pc_q;
  assign sp     = sp_q;
  assign status = st_q;
  assign busy   = (state_q != SQ_IDLE);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int          NUM_SRC    = 4,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_RST    = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ    = 16'hFFFE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               insn_start,
  input  logic               jammed,
  input  logic               nmi_req,
  input  logic [NUM_SRC-1:0] irq_set,
  input  logic [NUM_SRC-1:0] irq_clr,
  input  logic               irq_temp,
  input  logic               pc_we,
  input  logic [15:0]        pc_wdata,
  input  logic               st_we,
  input  logic [7:0]         st_wdata,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_we,
  output logic [15:0]        mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic [15:0]        pc,
  output logic [7:0]         sp,
  output logic [7:0]         status,
  output logic               busy
);
  logic nmi_pend, irq_pend, nmi_ack, boundary;

  irqseq_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_set(irq_set), .irq_clr(irq_clr),
    .irq_temp(irq_temp), .nmi_req(nmi_req), .nmi_ack(nmi_ack),
    .boundary(boundary), .nmi_pend(nmi_pend), .irq_pend(irq_pend)
  );

  irqseq_ctrl #(
    .STACK_PAGE(STACK_PAGE), .VEC_NMI(VEC_NMI), .VEC_RST(VEC_RST), .VEC_IRQ(VEC_IRQ)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .jammed(jammed),
    .nmi_pend(nmi_pend), .irq_pend(irq_pend), .pc_we(pc_we), .pc_wdata(pc_wdata),
    .st_we(st_we), .st_wdata(st_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .nmi_ack(nmi_ack), .boundary(boundary), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc(pc), .sp(sp), .status(status),
    .busy(busy)
  );
endmodule

// File: rtl/irqseq_chk.sv
module irqseq_chk #(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_start,
  input logic        jammed,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic [7:0]  sp,
  input logic [7:0]  status,
  input logic        busy
);
  logic [1:0] wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                               wr_cnt <= '0;
    else if (!busy)                           wr_cnt <= '0;
    else if (mem_valid && mem_ready && mem_we) wr_cnt <= wr_cnt + 2'd1;
  end

  assert_push_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_addr[15:8] == STACK_PAGE && mem_addr[7:0] == sp);

  assert_sp_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_we |=> sp == $past(sp) - 8'd1);

  assert_status_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && wr_cnt == 2'd2 |-> mem_wdata[5] && !mem_wdata[4]);

  assert_vector_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_we |-> mem_addr[15:8] == 8'hFF);

  assert_mask_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> status[2]);

  assert_jam_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    insn_start && jammed && !busy |=> !busy);

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
endmodule

bind irq_entry_seq irqseq_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .jammed(jammed),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sp(sp), .status(status), .busy(busy)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_start = 1'b0, jammed = 1'b0, nmi_req = 1'b0, irq_temp = 1'b0;
  logic [3:0]  irq_set = '0, irq_clr = '0;
  logic        pc_we = 1'b0, st_we = 1'b0;
  logic [15:0] pc_wdata = '0;
  logic [7:0]  st_wdata = '0;
  logic        mem_valid, mem_we, busy;
  logic        mem_ready = 1'b1;
  logic [15:0] mem_addr, pc;
  logic [7:0]  mem_wdata, mem_rdata, sp, status;

  int tests = 0, fails = 0;
  int log_n = 0;
  logic [15:0] log_addr [0:255];
  logic [7:0]  log_data [0:255];
  logic        log_we   [0:255];

  always #10 clk = ~clk;

  irq_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .jammed(jammed),
    .nmi_req(nmi_req), .irq_set(irq_set), .irq_clr(irq_clr), .irq_temp(irq_temp),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .st_we(st_we), .st_wdata(st_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc(pc), .sp(sp), .status(status), .busy(busy)
  );

  always_comb begin
    case (mem_addr)
      16'hFFFA: mem_rdata = 8'h34;
      16'hFFFB: mem_rdata = 8'h12;
      16'hFFFC: mem_rdata = 8'h00;
      16'hFFFD: mem_rdata = 8'h80;
      16'hFFFE: mem_rdata = 8'h78;
      16'hFFFF: mem_rdata = 8'h56;
      default:  mem_rdata = 8'h00;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready && log_n < 256) begin
      log_addr[log_n] = mem_addr;
      log_data[log_n] = mem_we ? mem_wdata : mem_rdata;
      log_we[log_n]   = mem_we;
      log_n = log_n + 1;
    end
  end

  initial begin
    #(20 * 20000);
    fails = fails + 1;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    tests = tests + 1;
    if (got !== exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic boundary();
    @(negedge clk); insn_start = 1'b1;
    @(negedge clk); insn_start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic set_status(input logic [7:0] v);
    @(negedge clk); st_we = 1'b1; st_wdata = v;
    @(negedge clk); st_we = 1'b0;
  endtask

  task automatic pulse_irq(input logic [3:0] s, input logic [3:0] c);
    @(negedge clk); irq_set = s; irq_clr = c;
    @(negedge clk); irq_set = '0; irq_clr = '0;
  endtask

  task automatic pulse_nmi();
    @(negedge clk); nmi_req = 1'b1;
    @(negedge clk); nmi_req = 1'b0;
  endtask

  task automatic check_entry(input int b, input logic [15:0] old_pc, input logic [7:0] old_st,
                             input logic [7:0] old_sp, input logic [15:0] vec, input logic [15:0] exp_pc);
    chk("R5", "push1 addr", log_addr[b], {8'h01, old_sp});
    chk("R5", "push1 data", log_data[b], old_pc[15:8]);
    chk("R5", "push2 addr", log_addr[b+1], {8'h01, 8'(old_sp - 8'd1)});
    chk("R5", "push2 data", log_data[b+1], old_pc[7:0]);
    chk("R5", "push3 addr", log_addr[b+2], {8'h01, 8'(old_sp - 8'd2)});
    chk("R6", "pushed status", log_data[b+2], (old_st & 8'hEF) | 8'h20);
    chk("R7", "vector lo read", {15'd0, log_we[b+3], log_addr[b+3]}, {16'd0, vec});
    chk("R7", "vector hi read", {15'd0, log_we[b+4], log_addr[b+4]}, {16'd0, 16'(vec + 16'd1)});
    chk("R7", "pc after entry", pc, exp_pc);
    chk("R7", "status after entry", status, old_st | 8'h04);
    chk("R5", "sp after entry", sp, 8'(old_sp - 8'd3));
  endtask

  task automatic t_reset();
    chk("R1", "busy in reset", busy, 1'b1);
    chk("R1", "status in reset", status, 8'h04);
    chk("R1", "sp in reset", sp, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    wait_idle();
    chk("R1", "first reset read", log_addr[0], 16'hFFFC);
    chk("R1", "second reset read", log_addr[1], 16'hFFFD);
    chk("R1", "pc from reset vector", pc, 16'h8000);
    chk("R1", "status after reset", status, 8'h04);
  endtask

  task automatic t_nmi_over_irq();
    int b;
    int cyc = 0;
    @(negedge clk); pc_we = 1'b1; pc_wdata = 16'hABCD;
    @(negedge clk); pc_we = 1'b0;
    set_status(8'h00);
    boundary();
    chk("R3", "no entry without request", busy, 1'b0);
    @(negedge clk); nmi_req = 1'b1; irq_set = 4'b0010;
    @(negedge clk); nmi_req = 1'b0; irq_set = '0;
    b = log_n;
    boundary();
    while (busy) begin cyc = cyc + 1; @(negedge clk); end
    chk("R8", "entry length", cyc, 7);
    chk("R2", "nmi vector chosen", log_addr[b+3], 16'hFFFA);
    check_entry(b, 16'hABCD, 8'h00, 8'h00, 16'hFFFA, 16'h1234);
  endtask

  task automatic t_skip_after_entry();
    int b;
    pulse_nmi();
    set_status(8'hD3);
    boundary();
    chk("R12", "no entry at first boundary after entry", busy, 1'b0);
    b = log_n;
    boundary();
    wait_idle();
    chk("R2", "nmi again ahead of irq", log_addr[b+3], 16'hFFFA);
    check_entry(b, 16'h1234, 8'hD3, 8'hFD, 16'hFFFA, 16'h1234);
  endtask

  task automatic t_irq_taken();
    int b;
    set_status(8'h00);
    boundary();
    b = log_n;
    boundary();
    wait_idle();
    chk("R2", "irq taken after nmi", log_addr[b+3], 16'hFFFE);
    check_entry(b, 16'h1234, 8'h00, 8'hFA, 16'hFFFE, 16'h5678);
    pulse_irq(4'b0000, 4'b0010);
  endtask

  task automatic t_mask_latch();
    int b;
    boundary();
    pulse_irq(4'b0001, 4'b0000);
    set_status(8'h00);
    boundary();
    chk("R3", "irq masked by I from previous boundary", busy, 1'b0);
    b = log_n;
    boundary();
    wait_idle();
    check_entry(b, 16'h5678, 8'h00, 8'hF7, 16'hFFFE, 16'h5678);
    pulse_irq(4'b0000, 4'b0001);
  endtask

  task automatic t_set_release();
    int b;
    set_status(8'h00);
    boundary();
    pulse_irq(4'b0100, 4'b0100);
    boundary();
    chk("R9", "release wins over set", busy, 1'b0);
    pulse_irq(4'b1100, 4'b0000);
    pulse_irq(4'b0000, 4'b0100);
    b = log_n;
    boundary();
    wait_idle();
    chk("R9", "remaining source keeps irq pending", log_n - b, 5);
    check_entry(b, 16'h5678, 8'h00, 8'hF4, 16'hFFFE, 16'h5678);
    pulse_irq(4'b0000, 4'b1000);
  endtask

  task automatic t_one_shot();
    int b;
    set_status(8'h04);
    boundary();
    @(negedge clk); irq_temp = 1'b1;
    @(negedge clk); irq_temp = 1'b0;
    boundary();
    chk("R10", "one-shot masked", busy, 1'b0);
    set_status(8'h00);
    boundary();
    chk("R10", "still masked by latched I", busy, 1'b0);
    boundary();
    chk("R10", "one-shot dropped at boundary", busy, 1'b0);
    @(negedge clk); irq_temp = 1'b1;
    @(negedge clk); irq_temp = 1'b0;
    b = log_n;
    boundary();
    wait_idle();
    check_entry(b, 16'h5678, 8'h00, 8'hF1, 16'hFFFE, 16'h5678);
  endtask

  task automatic t_jam_and_stall();
    int b;
    set_status(8'h00);
    boundary();
    @(negedge clk); jammed = 1'b1;
    pulse_nmi();
    boundary();
    chk("R4", "no entry while jammed", busy, 1'b0);
    @(negedge clk); jammed = 1'b0; mem_ready = 1'b0;
    b = log_n;
    boundary();
    chk("R4", "nmi kept pending through jam", busy, 1'b1);
    repeat (6) @(negedge clk);
    chk("R11", "stalled request valid", mem_valid, 1'b1);
    chk("R11", "stalled request addr", mem_addr, 16'h01EE);
    chk("R11", "stalled request data", mem_wdata, 8'h56);
    chk("R11", "still busy while stalled", busy, 1'b1);
    mem_ready = 1'b1;
    wait_idle();
    check_entry(b, 16'h5678, 8'h00, 8'hEE, 16'hFFFA, 16'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_nmi_over_irq();
    t_skip_after_entry();
    t_irq_taken();
    t_mask_latch();
    t_set_release();
    t_one_shot();
    t_jam_and_stall();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule